// File: doc/BRIEF.md
# PoE Powered-Device Input Sequencer

This block is the digital controller for the input side of a Power over Ethernet powered device. It reads sampled codes for the line voltage and for the hot-swap switch drain-source voltage, all in 10 mV units. It also reads:

- a flag that says the switch gate drive is high enough;
- two temperature flags, warning and critical;
- two auxiliary-supply flags.

From these it drives the signature-resistor enable, the classification enable, the hot-swap gate enable, a current-limit code in milliamps and an active-low power-good output.

The line voltage moves the device through several bands: signature, classification, waiting for undervoltage release, inrush and powered. Each band edge has hysteresis where the requirements call for it. During inrush the current limit steps with the switch voltage, so the switch dissipates roughly constant power. Once power-good is asserted, a continuous limit takes over. Inputs, including the programmed limits, are captured on a sample strobe. Two inputs are the exception: the critical-temperature flag and the prevalent auxiliary flag can be captured every clock, so that they remove the gate drive quickly. All outputs are registered one clock after capture.

Top module: `poe_pd_seq`

## Requirements
- R1: While reset is asserted, sig_en, cls_en and gate_en are 0, ilim_ma is 0 and pg_n is 1.
- R2: Strobed inputs are captured only on a clock edge with smp_vld high. Outputs reflect a capture at the next clock edge. A changed line code without a strobe leaves every output unchanged.
- R3: sig_en is 1 exactly when the captured line code is between 150 and 1150 inclusive.
- R4: The classification window opens when the line code exceeds 1150 and closes again below 1010. The window is cut off when the code exceeds 2300 and cleared again below 2150. cls_en follows this window when no detach cause is present.
- R5: gate_en turns on when the line code exceeds 3850 and turns off when it falls below 3150. Between those values it holds its state.
- R6: With the gate on and power-good not asserted, the limit is 140 for a switch code above 3000, 250 for a code above 1500 up to 3000, and 440 otherwise. With the gate off the limit is 0.
- R7: A programmed inrush maximum caps every inrush step. The value 0 selects the default of 440; any other value is first clamped to the range 140 to 440.
- R8: pg_n goes low when the gate is on, the switch code is below 150 and vgs_ok is 1. It stays low until the switch code reaches 300 or the gate turns off.
- R9: While pg_n is low, the limit is the programmed continuous limit. The value 0 selects 440; any other value is clamped to the range 150 to 800.
- R10: cls_en is forced to 0 by aux_local, aux_prevail, therm_warn or therm_crit. It is also forced to 0 once the gate has turned on, until the line code falls below 1010.
- R11: With therm_warn set, the gate on and the switch code above 300, the limit is 140 and overrides every other choice.
- R12: therm_crit removes gate_en and power-good within two clock edges, with no sample strobe needed.
- R13: aux_prevail removes gate_en within two clock edges, whatever the line voltage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | Sample strobe for the measured codes and programmed limits |
| vin_code | input | VW | Line voltage, 10 mV per LSB |
| vds_code | input | VW | Hot-swap drain-source voltage, 10 mV per LSB |
| vgs_ok | input | 1 | Gate-source voltage above 2 V |
| therm_warn | input | 1 | First temperature level reached |
| therm_crit | input | 1 | Second temperature level reached |
| aux_local | input | 1 | Auxiliary source connected ahead of the switch |
| aux_prevail | input | 1 | Auxiliary source feeding the converter directly |
| inrush_max_ma | input | LW | Programmed inrush maximum, mA (0 = default) |
| dc_lim_ma | input | LW | Programmed continuous limit, mA (0 = default) |
| sig_en | output | 1 | Signature resistor enable |
| cls_en | output | 1 | Classification current enable |
| gate_en | output | 1 | Hot-swap gate enable |
| ilim_ma | output | LW | Selected current limit, mA |
| pg_n | output | 1 | Power good, active low |

## Verification
The properties assume that the measured codes and the strobed flags change only together with smp_vld, or while it is low, so that every output change can be traced to a capture two edges earlier. They also assume that therm_crit and aux_prevail are held for at least two clocks. The stimulus therefore drives every input at the falling clock edge, pulses the strobe for exactly one cycle and holds the trip flags for several cycles. A scenario that needs a line code to be ignored changes it without a strobe and then watches the outputs.

// File: rtl/poe_pd_pkg.sv
package poe_pd_pkg;
   // line voltage bands, 10 mV units
   localparam int SIG_LO_C       = 150;
   localparam int SIG_HI_C       = 1150;
   localparam int CLS_OPEN_C     = 1150;
   localparam int CLS_SHUT_C     = 1010;
   localparam int CLS_CUT_C      = 2300;
   localparam int CLS_UNCUT_C    = 2150;
   localparam int UV_REL_C       = 3850;
   localparam int UV_LOCK_C      = 3150;
   // switch voltage bands, 10 mV units
   localparam int STEP_HI_C      = 3000;
   localparam int STEP_LO_C      = 1500;
   localparam int PG_SET_C       = 150;
   localparam int PG_CLR_C       = 300;
   localparam int WARN_VDS_C     = 300;
   // limits, mA
   localparam int LIM_LOW_C      = 140;
   localparam int LIM_MID_C      = 250;
   localparam int LIM_TOP_C      = 440;
   localparam int DC_MIN_C       = 150;
   localparam int DC_MAX_C       = 800;
   localparam int DC_DEF_C       = 440;
   localparam int MIN_VW_C       = 14;
   localparam int MIN_LW_C       = 10;
endpackage

// File: rtl/pd_sample_reg.sv
module pd_sample_reg #(
   parameter int VW = 14,
   parameter int LW = 10,
   parameter bit FAST_TRIP = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_vld,
   input  logic [VW-1:0] vin_code,
   input  logic [VW-1:0] vds_code,
   input  logic          vgs_ok,
   input  logic          therm_warn,
   input  logic          therm_crit,
   input  logic          aux_local,
   input  logic          aux_prevail,
   input  logic [LW-1:0] inrush_max_ma,
   input  logic [LW-1:0] dc_lim_ma,
   output logic [VW-1:0] vin_q,
   output logic [VW-1:0] vds_q,
   output logic          vgs_q,
   output logic          warn_q,
   output logic          crit_q,
   output logic          auxl_q,
   output logic          auxp_q,
   output logic [LW-1:0] irm_q,
   output logic [LW-1:0] dcl_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vin_q  <= '0;
         vds_q  <= '0;
         vgs_q  <= 1'b0;
         warn_q <= 1'b0;
         auxl_q <= 1'b0;
         irm_q  <= '0;
         dcl_q  <= '0;
      end else if (smp_vld) begin
         vin_q  <= vin_code;
         vds_q  <= vds_code;
         vgs_q  <= vgs_ok;
         warn_q <= therm_warn;
         auxl_q <= aux_local;
         irm_q  <= inrush_max_ma;
         dcl_q  <= dc_lim_ma;
      end
   end

   // trip flags: every clock, or only with the strobe
   generate
      if (FAST_TRIP) begin : g_fast_trip
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               crit_q <= 1'b0;
               auxp_q <= 1'b0;
            end else begin
               crit_q <= therm_crit;
               auxp_q <= aux_prevail;
            end
         end
      end else begin : g_strobe_trip
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               crit_q <= 1'b0;
               auxp_q <= 1'b0;
            end else if (smp_vld) begin
               crit_q <= therm_crit;
               auxp_q <= aux_prevail;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/pd_phase_ctl.sv
module pd_phase_ctl
   import poe_pd_pkg::*;
#(
   parameter int VW = 14
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [VW-1:0] vin_q,
   input  logic          warn_q,
   input  logic          crit_q,
   input  logic          auxl_q,
   input  logic          auxp_q,
   output logic          gate_nxt,
   output logic          sig_en,
   output logic          cls_en,
   output logic          gate_en
);
   localparam logic [VW-1:0] T_SIG_LO = VW'(SIG_LO_C);
   localparam logic [VW-1:0] T_SIG_HI = VW'(SIG_HI_C);
   localparam logic [VW-1:0] T_OPEN   = VW'(CLS_OPEN_C);
   localparam logic [VW-1:0] T_SHUT   = VW'(CLS_SHUT_C);
   localparam logic [VW-1:0] T_CUT    = VW'(CLS_CUT_C);
   localparam logic [VW-1:0] T_UNCUT  = VW'(CLS_UNCUT_C);
   localparam logic [VW-1:0] T_REL    = VW'(UV_REL_C);
   localparam logic [VW-1:0] T_LOCK   = VW'(UV_LOCK_C);

   logic win_r, cut_r, uv_r, done_r;
   logic win_n, cut_n, uv_n, done_n, sig_n, cls_n;

   always_comb begin
      win_n = win_r;
      if (vin_q > T_OPEN)      win_n = 1'b1;
      else if (vin_q < T_SHUT) win_n = 1'b0;

      cut_n = cut_r;
      if (vin_q > T_CUT)        cut_n = 1'b1;
      else if (vin_q < T_UNCUT) cut_n = 1'b0;

      uv_n = uv_r;
      if (vin_q > T_REL)       uv_n = 1'b1;
      else if (vin_q < T_LOCK) uv_n = 1'b0;

      gate_nxt = uv_n & ~crit_q & ~auxp_q;
      done_n   = win_n & (done_r | gate_nxt);
      sig_n    = (vin_q >= T_SIG_LO) && (vin_q <= T_SIG_HI);
      cls_n    = win_n & ~cut_n & ~done_n & ~auxl_q & ~auxp_q & ~warn_q & ~crit_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_r   <= 1'b0;
         cut_r   <= 1'b0;
         uv_r    <= 1'b0;
         done_r  <= 1'b0;
         sig_en  <= 1'b0;
         cls_en  <= 1'b0;
         gate_en <= 1'b0;
      end else begin
         win_r   <= win_n;
         cut_r   <= cut_n;
         uv_r    <= uv_n;
         done_r  <= done_n;
         sig_en  <= sig_n;
         cls_en  <= cls_n;
         gate_en <= gate_nxt;
      end
   end
endmodule

// File: rtl/pd_pgood.sv
module pd_pgood
   import poe_pd_pkg::*;
#(
   parameter int VW = 14
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          gate_nxt,
   input  logic [VW-1:0] vds_q,
   input  logic          vgs_q,
   output logic          pg_nxt,
   output logic          pg_n
);
   localparam logic [VW-1:0] T_SET = VW'(PG_SET_C);
   localparam logic [VW-1:0] T_CLR = VW'(PG_CLR_C);

   always_comb begin
      if (!pg_n) pg_nxt = gate_nxt && (vds_q < T_CLR);
      else       pg_nxt = gate_nxt && (vds_q < T_SET) && vgs_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pg_n <= 1'b1;
      else        pg_n <= ~pg_nxt;
   end
endmodule

// File: rtl/pd_limit_sel.sv
module pd_limit_sel
   import poe_pd_pkg::*;
#(
   parameter int VW = 14,
   parameter int LW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          gate_nxt,
   input  logic          pg_nxt,
   input  logic          warn_q,
   input  logic [VW-1:0] vds_q,
   input  logic [LW-1:0] irm_q,
   input  logic [LW-1:0] dcl_q,
   output logic [LW-1:0] ilim_ma
);
   localparam logic [VW-1:0] T_STEP_HI = VW'(STEP_HI_C);
   localparam logic [VW-1:0] T_STEP_LO = VW'(STEP_LO_C);
   localparam logic [VW-1:0] T_WARN    = VW'(WARN_VDS_C);
   localparam logic [LW-1:0] L_LOW     = LW'(LIM_LOW_C);
   localparam logic [LW-1:0] L_MID     = LW'(LIM_MID_C);
   localparam logic [LW-1:0] L_TOP     = LW'(LIM_TOP_C);
   localparam logic [LW-1:0] L_DCMIN   = LW'(DC_MIN_C);
   localparam logic [LW-1:0] L_DCMAX   = LW'(DC_MAX_C);
   localparam logic [LW-1:0] L_DCDEF   = LW'(DC_DEF_C);

   logic [LW-1:0] cap, step, inrush, dc, lim_n;

   always_comb begin
      // programmed inrush cap
      if (irm_q == '0)        cap = L_TOP;
      else if (irm_q < L_LOW) cap = L_LOW;
      else if (irm_q > L_TOP) cap = L_TOP;
      else                    cap = irm_q;

      if (vds_q > T_STEP_HI)      step = L_LOW;
      else if (vds_q > T_STEP_LO) step = L_MID;
      else                        step = L_TOP;
      inrush = (step < cap) ? step : cap;

      // continuous limit
      if (dcl_q == '0)          dc = L_DCDEF;
      else if (dcl_q < L_DCMIN) dc = L_DCMIN;
      else if (dcl_q > L_DCMAX) dc = L_DCMAX;
      else                      dc = dcl_q;

      if (!gate_nxt)                    lim_n = '0;
      else if (warn_q && vds_q > T_WARN) lim_n = L_LOW;
      else if (pg_nxt)                  lim_n = dc;
      else                              lim_n = inrush;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ilim_ma <= '0;
      else        ilim_ma <= lim_n;
   end
endmodule

// File: rtl/poe_pd_seq.sv
module poe_pd_seq
   import poe_pd_pkg::*;
#(
   parameter int VW = 14,
   parameter int LW = 10,
   parameter bit FAST_TRIP = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_vld,
   input  logic [VW-1:0] vin_code,
   input  logic [VW-1:0] vds_code,
   input  logic          vgs_ok,
   input  logic          therm_warn,
   input  logic          therm_crit,
   input  logic          aux_local,
   input  logic          aux_prevail,
   input  logic [LW-1:0] inrush_max_ma,
   input  logic [LW-1:0] dc_lim_ma,
   output logic          sig_en,
   output logic          cls_en,
   output logic          gate_en,
   output logic [LW-1:0] ilim_ma,
   output logic          pg_n
);
   generate
      if (VW < MIN_VW_C) begin : g_bad_vw
         $error("poe_pd_seq: VW too narrow for 100 V in 10 mV units");
      end
      if (LW < MIN_LW_C) begin : g_bad_lw
         $error("poe_pd_seq: LW too narrow for an 800 mA code");
      end
   endgenerate

   logic [VW-1:0] vin_q, vds_q;
   logic [LW-1:0] irm_q, dcl_q;
   logic          vgs_q, warn_q, crit_q, auxl_q, auxp_q;
   logic          gate_nxt, pg_nxt;

   pd_sample_reg #(.VW(VW), .LW(LW), .FAST_TRIP(FAST_TRIP)) u_smp (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
      .vin_code(vin_code), .vds_code(vds_code), .vgs_ok(vgs_ok),
      .therm_warn(therm_warn), .therm_crit(therm_crit),
      .aux_local(aux_local), .aux_prevail(aux_prevail),
      .inrush_max_ma(inrush_max_ma), .dc_lim_ma(dc_lim_ma),
      .vin_q(vin_q), .vds_q(vds_q), .vgs_q(vgs_q), .warn_q(warn_q),
      .crit_q(crit_q), .auxl_q(auxl_q), .auxp_q(auxp_q),
      .irm_q(irm_q), .dcl_q(dcl_q)
   );

   pd_phase_ctl #(.VW(VW)) u_phase (
      .clk(clk), .rst_n(rst_n), .vin_q(vin_q), .warn_q(warn_q),
      .crit_q(crit_q), .auxl_q(auxl_q), .auxp_q(auxp_q),
      .gate_nxt(gate_nxt), .sig_en(sig_en), .cls_en(cls_en),
      .gate_en(gate_en)
   );

   pd_pgood #(.VW(VW)) u_pg (
      .clk(clk), .rst_n(rst_n), .gate_nxt(gate_nxt), .vds_q(vds_q),
      .vgs_q(vgs_q), .pg_nxt(pg_nxt), .pg_n(pg_n)
   );

   pd_limit_sel #(.VW(VW), .LW(LW)) u_lim (
      .clk(clk), .rst_n(rst_n), .gate_nxt(gate_nxt), .pg_nxt(pg_nxt),
      .warn_q(warn_q), .vds_q(vds_q), .irm_q(irm_q), .dcl_q(dcl_q),
      .ilim_ma(ilim_ma)
   );
endmodule

// File: rtl/poe_pd_seq_chk.sv
module poe_pd_seq_chk #(
   parameter int LW = 10,
   parameter bit FAST_TRIP = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          smp_vld,
   input logic          therm_crit,
   input logic          aux_prevail,
   input logic          sig_en,
   input logic          gate_en,
   input logic [LW-1:0] ilim_ma,
   input logic          pg_n
);
   localparam logic [LW-1:0] C_LOW = LW'(140);
   localparam logic [LW-1:0] C_MAX = LW'(800);

   a_r2_sig_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(smp_vld, 2) |-> $stable(sig_en));

   a_r5_gate_excludes_sig: assert property (@(posedge clk) disable iff (!rst_n)
      gate_en |-> !sig_en);

   a_r6_no_limit_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_en |-> ilim_ma == '0);

   a_r8_pg_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !pg_n |-> gate_en);

   a_r9_limit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      gate_en |-> (ilim_ma >= C_LOW && ilim_ma <= C_MAX));

   generate
      if (FAST_TRIP) begin : g_trip_chk
         a_r12_crit_trip: assert property (@(posedge clk) disable iff (!rst_n)
            therm_crit |=> ##1 (!gate_en && pg_n));
         a_r13_aux_trip: assert property (@(posedge clk) disable iff (!rst_n)
            aux_prevail |=> ##1 !gate_en);
      end
   endgenerate
endmodule

bind poe_pd_seq poe_pd_seq_chk #(.LW(LW), .FAST_TRIP(FAST_TRIP)) u_chk (
   .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .therm_crit(therm_crit),
   .aux_prevail(aux_prevail), .sig_en(sig_en), .gate_en(gate_en),
   .ilim_ma(ilim_ma), .pg_n(pg_n)
);

// File: tb/poe_pd_seq_test.sv
module poe_pd_seq_test;
   localparam int CLK_P = 10;
   localparam int NV = 36;

   typedef struct packed {
      logic [3:0]  req;
      logic [13:0] vin;
      logic [13:0] vds;
      logic        vgs;
      logic [9:0]  irm;
      logic [9:0]  dcl;
      logic        thw;
      logic        auxl;
      logic        sig;
      logic        cls;
      logic        gate;
      logic [9:0]  lim;
      logic        pgn;
   } vec_t;

   // req, vin, vds, vgs, irm, dcl, warn, auxl | sig, cls, gate, lim, pg_n
   localparam vec_t VEC [NV] = '{
      '{4'd3, 14'd100,  14'd5000, 1'b0, 10'd0,   10'd0,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd0,   1'b1}, // R3
      '{4'd3, 14'd150,  14'd5000, 1'b0, 10'd0,   10'd0,   1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 10'd0,   1'b1}, // R3
      '{4'd3, 14'd1150, 14'd5000, 1'b0, 10'd0,   10'd0,   1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 10'd0,   1'b1}, // R3
      '{4'd4, 14'd1151, 14'd5000, 1'b0, 10'd0,   10'd0,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 10'd0,   1'b1}, // R4
      '{4'd4, 14'd1050, 14'd5000, 1'b0, 10'd0,   10'd0,   1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'd0,   1'b1}, // R4
      '{4'd4, 14'd1009, 14'd5000, 1'b0, 10'd0,   10'd0,   1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 10'd0,   1'b1}, // R4
      '{4'd4, 14'd1200, 14'd5000, 1'b0, 10'd0,   10'd0,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 10'd0,   1'b1}, // R4
      '{4'd4, 14'd2300, 14'd5000, 1'b0, 10'd0,   10'd0,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 10'd0,   1'b1}, // R4
      '{4'd4, 14'd2301, 14'd5000, 1'b0, 10'd0,   10'd0,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd0,   1'b1}, // R4
      '{4'd4, 14'd2200, 14'd5000, 1'b0, 10'd0,   10'd0,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd0,   1'b1}, // R4
      '{4'd4, 14'd2149, 14'd5000, 1'b0, 10'd0,   10'd0,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 10'd0,   1'b1}, // R4
      '{4'd5, 14'd3850, 14'd5000, 1'b0, 10'd0,   10'd0,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd0,   1'b1}, // R5
      '{4'd5, 14'd3851, 14'd5000, 1'b0, 10'd0,   10'd0,   1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd140, 1'b1}, // R5
      '{4'd6, 14'd4800, 14'd3000, 1'b0, 10'd0,   10'd0,   1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd250, 1'b1}, // R6
      '{4'd6, 14'd4800, 14'd1500, 1'b0, 10'd0,   10'd0,   1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd440, 1'b1}, // R6
      '{4'd7, 14'd4800, 14'd1500, 1'b0, 10'd200, 10'd0,   1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd200, 1'b1}, // R7
      '{4'd7, 14'd4800, 14'd2000, 1'b0, 10'd200, 10'd0,   1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd200, 1'b1}, // R7
      '{4'd7, 14'd4800, 14'd5000, 1'b0, 10'd200, 10'd0,   1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd140, 1'b1}, // R7
      '{4'd7, 14'd4800, 14'd1000, 1'b0, 10'd50,  10'd0,   1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd140, 1'b1}, // R7
      '{4'd8, 14'd4800, 14'd149,  1'b0, 10'd0,   10'd0,   1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd440, 1'b1}, // R8
      '{4'd8, 14'd4800, 14'd149,  1'b1, 10'd0,   10'd0,   1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd440, 1'b0}, // R8
      '{4'd9, 14'd4800, 14'd299,  1'b1, 10'd0,   10'd800, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd800, 1'b0}, // R9
      '{4'd9, 14'd4800, 14'd299,  1'b1, 10'd0,   10'd900, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd800, 1'b0}, // R9
      '{4'd9, 14'd4800, 14'd299,  1'b1, 10'd0,   10'd100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd150, 1'b0}, // R9
      '{4'd11,14'd4800, 14'd299,  1'b1, 10'd0,   10'd300, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 10'd300, 1'b0}, // R11
      '{4'd11,14'd4800, 14'd301,  1'b1, 10'd0,   10'd300, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 10'd140, 1'b1}, // R11
      '{4'd8, 14'd4800, 14'd200,  1'b1, 10'd0,   10'd300, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd440, 1'b1}, // R8
      '{4'd8, 14'd4800, 14'd100,  1'b1, 10'd0,   10'd300, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd300, 1'b0}, // R8
      '{4'd5, 14'd3200, 14'd100,  1'b1, 10'd0,   10'd300, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd300, 1'b0}, // R5
      '{4'd5, 14'd3149, 14'd100,  1'b1, 10'd0,   10'd300, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd0,   1'b1}, // R5
      '{4'd10,14'd2100, 14'd100,  1'b1, 10'd0,   10'd300, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd0,   1'b1}, // R10
      '{4'd10,14'd1000, 14'd100,  1'b1, 10'd0,   10'd300, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 10'd0,   1'b1}, // R10
      '{4'd4, 14'd1200, 14'd100,  1'b1, 10'd0,   10'd300, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 10'd0,   1'b1}, // R4
      '{4'd10,14'd1200, 14'd100,  1'b1, 10'd0,   10'd300, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10'd0,   1'b1}, // R10
      '{4'd10,14'd1200, 14'd100,  1'b1, 10'd0,   10'd300, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 10'd0,   1'b1}, // R10
      '{4'd10,14'd1200, 14'd100,  1'b1, 10'd0,   10'd300, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 10'd0,   1'b1}  // R10
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_vld = 1'b0;
   logic [13:0] vin_code = '0, vds_code = '0;
   logic        vgs_ok = 1'b0, therm_warn = 1'b0, therm_crit = 1'b0;
   logic        aux_local = 1'b0, aux_prevail = 1'b0;
   logic [9:0]  inrush_max_ma = '0, dc_lim_ma = '0;
   logic        sig_en, cls_en, gate_en, pg_n;
   logic [9:0]  ilim_ma;
   int          checks = 0, errors = 0;
   bit          finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   poe_pd_seq uut (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .vin_code(vin_code),
      .vds_code(vds_code), .vgs_ok(vgs_ok), .therm_warn(therm_warn),
      .therm_crit(therm_crit), .aux_local(aux_local), .aux_prevail(aux_prevail),
      .inrush_max_ma(inrush_max_ma), .dc_lim_ma(dc_lim_ma), .sig_en(sig_en),
      .cls_en(cls_en), .gate_en(gate_en), .ilim_ma(ilim_ma), .pg_n(pg_n)
   );

   function automatic logic [13:0] outs();
      return {sig_en, cls_en, gate_en, ilim_ma, pg_n};
   endfunction

   task automatic check(input string req, input logic [13:0] exp);
      checks++;
      if (outs() !== exp) begin
         errors++;
         $display("FAIL %s: {sig,cls,gate,lim,pg_n} actual %b/%b/%b/%0d/%b expected %b/%b/%b/%0d/%b",
                  req, sig_en, cls_en, gate_en, ilim_ma, pg_n,
                  exp[13], exp[12], exp[11], exp[10:1], exp[0]);
      end
   endtask

   // one strobe at a falling edge, then two rising edges, then sample
   task automatic strobe();
      smp_vld = 1'b1;
      @(posedge clk);
      @(negedge clk);
      smp_vld = 1'b0;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wait_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(CLK_P * 20000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      wait_cycles(3);
      check("R1", {1'b0, 1'b0, 1'b0, 10'd0, 1'b1});
      rst_n = 1'b1;
      wait_cycles(2);
      check("R1", {1'b0, 1'b0, 1'b0, 10'd0, 1'b1});

      for (int i = 0; i < NV; i++) begin
         vin_code = VEC[i].vin;  vds_code = VEC[i].vds;  vgs_ok = VEC[i].vgs;
         inrush_max_ma = VEC[i].irm;  dc_lim_ma = VEC[i].dcl;
         therm_warn = VEC[i].thw;  aux_local = VEC[i].auxl;
         strobe();
         check($sformatf("R%0d vec%0d", VEC[i].req, i),
               {VEC[i].sig, VEC[i].cls, VEC[i].gate, VEC[i].lim, VEC[i].pgn});
      end

      // gate on again for the trip tests
      vin_code = 14'd4000; vds_code = 14'd5000; vgs_ok = 1'b0;
      strobe();
      check("R5 regate", {1'b0, 1'b0, 1'b1, 10'd140, 1'b1});

      // R12: critical temperature, no strobe
      therm_crit = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      check("R12 trip", {1'b0, 1'b0, 1'b0, 10'd0, 1'b1});
      therm_crit = 1'b0;
      wait_cycles(3);
      check("R12 release", {1'b0, 1'b0, 1'b1, 10'd140, 1'b1});

      // R13: prevalent auxiliary source, no strobe
      aux_prevail = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      check("R13 trip", {1'b0, 1'b0, 1'b0, 10'd0, 1'b1});
      aux_prevail = 1'b0;
      wait_cycles(3);
      check("R13 release", {1'b0, 1'b0, 1'b1, 10'd140, 1'b1});

      // R2: line code change without strobe is ignored
      vin_code = 14'd500;
      wait_cycles(5);
      check("R2 no strobe", {1'b0, 1'b0, 1'b1, 10'd140, 1'b1});
      strobe();
      check("R2 strobe", {1'b1, 1'b0, 1'b0, 10'd0, 1'b1});

      // R1: reset in the middle of operation
      vin_code = 14'd4000; vds_code = 14'd100; vgs_ok = 1'b1;
      strobe();
      check("R8 before reset", {1'b0, 1'b0, 1'b1, 10'd300, 1'b0});
      rst_n = 1'b0;
      wait_cycles(1);
      check("R1 mid-run", {1'b0, 1'b0, 1'b0, 10'd0, 1'b1});
      rst_n = 1'b1;

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule